// File: doc/BRIEF.md
# Streaming Page Load Scan Register

This block is a test data register for a JTAG port that presents itself to the scan host as one long chain, as many bits as a full memory page (2048 bits for a 256-byte page). Inside it holds only a byte-wide shifter and a bit counter. While the register is selected and the TAP sits in Shift-DR, serial data from TDI fills the shifter least significant bit first. Each time eight bits have arrived, the finished byte goes out on a byte-wide page buffer write port at an address that starts from zero and steps up by one per byte.

A host loads a whole page in one scan. It selects the register through the instruction register, passes through Capture-DR to restart at byte zero, and then clocks the page through Shift-DR. The first bit is the least significant bit of the first word in the page and the last bit is the most significant bit of the last word. Update-DR moves nothing, because every byte has already been stored by the time the scan ends.

Top module: `page_load_chain`

## Requirements
- R1: The block acts only while the 4-bit instruction input equals 4'h6. With any other code, Shift-DR and Capture-DR cause no page buffer write and leave the shifter, the bit count and the byte address unchanged.
- R2: Bits are taken least significant bit first. Byte n of a scan is made of stream bits 8n to 8n+7 since the last Capture-DR, and stream bit 8n+k becomes bit k of that byte.
- R3: The write strobe goes high for exactly one TCK cycle, starting at the rising TCK edge that shifts in the eighth bit of a byte. Address and data are valid while the strobe is high.
- R4: The bytes of a scan are written to addresses 0, 1, 2 and so on, in stream order, up to 255.
- R5: After byte address 255 the next byte goes to address 0.
- R6: Capture-DR while selected clears both the bit count and the byte address, and drops any partial byte. It does not write.
- R7: Update-DR causes no write and leaves the bit count and the byte address unchanged, so a scan carries on across it.
- R8: TDO is the shifter's least significant bit. After the n-th shift (n of at least 8) since Capture-DR, TDO equals stream bit n-8.
- R9: After reset the write strobe is low, the write address is 0 and TDO is 0.
- R10: With Shift-DR low and no Capture-DR, clock edges change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, the shifter's least significant bit |
| ir_i | input | 4 | Current instruction code |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| wr_en_o | output | 1 | Page buffer write strobe, one cycle per byte |
| wr_addr_o | output | 8 | Page buffer byte address |
| wr_data_o | output | 8 | Page buffer byte data |

## Verification
The bench streams a full page and a scan of 258 bytes. A design that lost the wrap would write bytes 256 and 257 to addresses that do not exist instead of overwriting bytes 0 and 1, and one that reversed the bit order would store mirrored bytes. It restarts a scan with Capture-DR in the middle of a byte, where a design that kept its bit count would commit a byte made of stale and new bits. It also steps through Update-DR and through a stretch with a different instruction in the middle of a byte. A design that reacted to either would emit an extra write or would break up the byte that was being assembled.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned DEF_IR_W       = 4;
  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_PAGE_BYTES = 256;
  localparam logic [DEF_IR_W-1:0] DEF_SEL_CODE = 4'h6;
endpackage

// File: rtl/pls_sel_decode.sv
module pls_sel_decode #(
  parameter int unsigned         IR_W     = pls_pkg::DEF_IR_W,
  parameter logic [IR_W-1:0]     SEL_CODE = pls_pkg::DEF_SEL_CODE
) (
  input  logic [IR_W-1:0] ir_i,
  input  logic            capture_i,
  input  logic            shift_i,
  output logic            sel_o,
  output logic            cap_o,
  output logic            shf_o
);
  assign sel_o = (ir_i == SEL_CODE);
  assign cap_o = sel_o & capture_i;
  assign shf_o = sel_o & shift_i & ~capture_i;
endmodule

// File: rtl/pls_byte_shifter.sv
module pls_byte_shifter #(
  parameter int unsigned BYTE_W = pls_pkg::DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shf_i,
  input  logic              tdi_i,
  output logic [BYTE_W-1:0] next_o,
  output logic              tdo_o
);
  logic [BYTE_W-1:0] sh_q;

  // LSB first: oldest bit ends in bit 0
  assign next_o = {tdi_i, sh_q[BYTE_W-1:1]};
  assign tdo_o  = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (shf_i) sh_q <= next_o;
  end

  // R8
  tdo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_i |=> tdo_o == $past(sh_q[1]));
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shf_i |=> $stable(sh_q));
endmodule

// File: rtl/pls_byte_sequencer.sv
module pls_byte_sequencer #(
  parameter int unsigned BYTE_W     = pls_pkg::DEF_BYTE_W,
  parameter int unsigned PAGE_BYTES = pls_pkg::DEF_PAGE_BYTES,
  localparam int unsigned CNT_W     = $clog2(BYTE_W),
  localparam int unsigned ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              shf_i,
  input  logic              sel_i,
  input  logic              update_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(PAGE_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              commit;

  assign commit = shf_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (cap_i) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (shf_i) begin
      cnt_q <= commit ? '0 : cnt_q + 1'b1;
      if (commit) addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= commit;
      if (commit) begin
        wr_addr_o <= addr_q;
        wr_data_o <= byte_i;
      end
    end
  end

  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != ADDR_LAST) |-> addr_q == wr_addr_o + 1'b1);
  // R5
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == ADDR_LAST) |-> addr_q == '0);
  // R6
  capture_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (cnt_q == '0 && addr_q == '0 && !wr_en_o));
  // R7
  update_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && update_i && !shf_i && !cap_i) |=> ($stable(cnt_q) && $stable(addr_q) && !wr_en_o));
endmodule

// File: rtl/page_load_chain.sv
module page_load_chain #(
  parameter int unsigned          IR_W       = pls_pkg::DEF_IR_W,
  parameter logic [IR_W-1:0]      SEL_CODE   = pls_pkg::DEF_SEL_CODE,
  parameter int unsigned          BYTE_W     = pls_pkg::DEF_BYTE_W,
  parameter int unsigned          PAGE_BYTES = pls_pkg::DEF_PAGE_BYTES,
  localparam int unsigned         ADDR_W     = $clog2(PAGE_BYTES)
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic              sel, cap, shf;
  logic [BYTE_W-1:0] next_byte;

  pls_sel_decode #(.IR_W(IR_W), .SEL_CODE(SEL_CODE)) i_decode (
    .ir_i      (ir_i),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .sel_o     (sel),
    .cap_o     (cap),
    .shf_o     (shf)
  );

  pls_byte_shifter #(.BYTE_W(BYTE_W)) i_shifter (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .shf_i  (shf),
    .tdi_i  (tdi_i),
    .next_o (next_byte),
    .tdo_o  (tdo_o)
  );

  pls_byte_sequencer #(.BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES)) i_seq (
    .clk_i     (tck_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .shf_i     (shf),
    .sel_i     (sel),
    .update_i  (update_dr_i),
    .byte_i    (next_byte),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  // R1
  desel_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel |=> !wr_en_o);
  // R10
  idle_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_dr_i && !capture_dr_i) |=> (!wr_en_o && $stable(tdo_o)));
endmodule

// File: tb/test_page_load_chain.sv
module test_page_load_chain;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tdi = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0;
  logic [3:0] ir = 4'h6;
  logic       tdo, wr_en;
  logic [7:0] wr_addr, wr_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [256];
  int   wr_cnt = 0;
  int   exp_addr = 0;
  logic hist [4096];
  int   nsh = 0;
  logic done = 1'b0;

  always #2 tck = ~tck;

  page_load_chain i_page_load_chain (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .tdo_o(tdo), .ir_i(ir),
    .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: one sample per cycle, strobe is registered
  always @(negedge tck) if (rst_n && wr_en) begin
    chk("R4 address order", 32'(wr_addr), 32'(exp_addr));
    mem[wr_addr] = wr_data;
    wr_cnt++;
    exp_addr = (exp_addr + 1) % 256;
  end

  // one TCK cycle; returns at the next falling edge
  task automatic cyc(input logic c, input logic s, input logic u, input logic d, input logic [3:0] code);
    cap = c; shf = s; upd = u; tdi = d; ir = code;
    @(negedge tck);
  endtask

  task automatic capture();
    exp_addr = 0; nsh = 0;
    cyc(1, 0, 0, 0, 4'h6);
  endtask

  task automatic sbit(input logic d);
    hist[nsh] = d;
    nsh++;
    cyc(0, 1, 0, d, 4'h6);
    if (nsh >= 8) chk("R8 tdo", 32'(tdo), 32'(hist[nsh-8]));
  endtask

  task automatic sbyte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) sbit(b[k]);
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    int w0;
    @(negedge tck); @(negedge tck);
    // R9
    chk("R9 reset strobe", 32'(wr_en), 0);
    chk("R9 reset addr", 32'(wr_addr), 0);
    chk("R9 reset tdo", 32'(tdo), 0);
    rst_n = 1'b1;
    @(negedge tck);

    // R2 R4: full page
    capture();
    w0 = wr_cnt;
    for (int i = 0; i < 256; i++) sbyte(pat_a(i));
    cyc(0, 0, 0, 0, 4'h6);
    chk("R3 one strobe per byte", 32'(wr_cnt - w0), 256);
    for (int i = 0; i < 256; i++) chk("R2 page byte", 32'(mem[i]), 32'(pat_a(i)));

    // R5: wrap
    capture();
    for (int i = 0; i < 258; i++) sbyte(8'(i) ^ 8'h5A);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R5 wrap byte0", 32'(mem[0]), 32'(8'h00 ^ 8'h5A));
    chk("R5 wrap byte1", 32'(mem[1]), 32'(8'h01 ^ 8'h5A));
    chk("R5 byte2 kept", 32'(mem[2]), 32'(8'h02 ^ 8'h5A));
    chk("R5 byte255", 32'(mem[255]), 32'(8'hFF ^ 8'h5A));

    // R6: capture mid-byte drops partial byte
    capture();
    for (int k = 0; k < 5; k++) sbit(1'b1);
    w0 = wr_cnt;
    capture();
    sbyte(8'h3C);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R6 single write", 32'(wr_cnt - w0), 1);
    chk("R6 restarted byte", 32'(mem[0]), 32'h3C);

    // R7: update mid-byte moves nothing
    capture();
    w0 = wr_cnt;
    for (int k = 0; k < 3; k++) sbit(k == 0 || k == 2);
    cyc(0, 0, 1, 0, 4'h6);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R7 no write on update", 32'(wr_cnt - w0), 0);
    for (int k = 3; k < 8; k++) sbit(k == 5 || k == 7);
    cyc(0, 0, 1, 0, 4'h6);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R7 byte across update", 32'(mem[0]), 32'hA5);
    chk("R7 write count", 32'(wr_cnt - w0), 1);
    sbyte(8'h77);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R7 address kept", 32'(mem[1]), 32'h77);

    // R1: other instruction mid-byte
    capture();
    for (int k = 0; k < 4; k++) sbit(k == 1 || k == 2);
    w0 = wr_cnt;
    begin
      logic t0;
      t0 = tdo;
      for (int k = 0; k < 16; k++) cyc(0, 1, 0, 1'b1, 4'h5);
      cyc(1, 0, 0, 0, 4'h5);
      for (int k = 0; k < 8; k++) cyc(0, 1, 0, 1'b0, 4'h7);
      chk("R1 no write deselected", 32'(wr_cnt - w0), 0);
      chk("R1 tdo held deselected", 32'(tdo), 32'(t0));
    end
    for (int k = 4; k < 8; k++) sbit(k == 4 || k == 7);
    cyc(0, 0, 0, 0, 4'h6);
    chk("R1 byte intact", 32'(mem[0]), 32'h96);
    chk("R1 write count", 32'(wr_cnt - w0), 1);

    // R10: idle clocks
    w0 = wr_cnt;
    begin
      logic t0;
      t0 = tdo;
      for (int k = 0; k < 20; k++) cyc(0, 0, 0, k[0], 4'h6);
      chk("R10 no write idle", 32'(wr_cnt - w0), 0);
      chk("R10 tdo idle", 32'(tdo), 32'(t0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule